// File: doc/BRIEF.md
# Bit-Serial Adder with Stored Carry

This block adds two unsigned operands using a single full-adder slice that is reused once per clock. A load pulse places the augend and the addend in two shift registers and clears the stored carry. While the shift enable is high, both registers shift right, so the operand bits leave at the least significant end. Each cycle the slice adds the two outgoing bits and the stored carry. The sum bit enters the augend register at its most significant end, and the carry flip-flop keeps the carry for the next cycle. After exactly `W` shift cycles, the augend register holds the sum and the carry flip-flop holds the carry-out.

The carry flip-flop has two update rules, selected at run time: a plain D-type rule (majority of the three inputs), or a JK-style rule that sets on two ones, clears on two zeros and holds otherwise. The addend register can feed its own outgoing bit back in, which keeps the addend intact. It can instead take an external serial bit. A down-counter armed by the load allows exactly `W` shifts. It pulses `done` in the cycle in which the finished sum first appears.

Top module: `serial_add_unit`

## Requirements
- R1: After reset, `result` is 0, `addend_out` is 0 and `done` is low.
- R2: A cycle with `load` high captures `augend_in` and `addend_in`, clears the stored carry and arms the counter for `W` shifts. It takes priority over `shift_en` in the same cycle, so the next cycle shows `result == {1'b0, augend_in}` and `addend_out == addend_in`.
- R3: The registers and the carry change only on a cycle with `shift_en` high, the counter nonzero and `load` low. On any other cycle, `result` and `addend_out` hold their values.
- R4: On each shift, the augend moves one place toward bit 0 and bit `W-1` receives the sum bit. The sum bit is augend bit 0 XOR addend bit 0 XOR the stored carry.
- R5: With `jk_mode` = 0, the carry takes the majority of augend bit 0, addend bit 0 and the old carry on each shift.
- R6: With `jk_mode` = 1, the carry sets when both outgoing bits are 1, clears when both are 0, and otherwise keeps its value on each shift.
- R7: On each shift, bit `W-1` of the addend receives the addend's own bit 0 when `addend_recirc` = 1, and `addend_ser_in` when it is 0.
- R8: After a load, exactly `W` shifts take place, however the enable is paused. `done` is high for exactly one cycle, the one that follows the final shift. No further shifts occur until the next load.
- R9: `result` is the `W+1`-bit value `{carry, augend}`. When `done` is high, it equals the sum of the loaded operands in both carry modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operands; clears carry and arms counter |
| augend_in | input | W | Augend for parallel load |
| addend_in | input | W | Addend for parallel load |
| shift_en | input | 1 | Allows a shift step while the counter is nonzero |
| jk_mode | input | 1 | Carry rule: 0 = D-type majority, 1 = JK-style set/clear/hold |
| addend_recirc | input | 1 | 1 = addend shifts in its own bit 0; 0 = takes addend_ser_in |
| addend_ser_in | input | 1 | External serial input of the addend register |
| result | output | W+1 | Stored carry (MSB) above the augend register |
| addend_out | output | W | Addend register contents |
| done | output | 1 | One-cycle pulse after the final shift |

## Verification
Every result is one register stage behind its cause. A load shows in `result` and `addend_out` one clock later. Each shift step shows its partial sum and carry one clock later. `done` and the finished sum appear together, in the cycle that follows the `W`-th enabled clock. The bench changes inputs on the falling edge and samples on the next falling edge, after exactly the counted rising edges. A paused stretch is sampled on every falling edge to confirm nothing moved. The cycle after `done` is sampled again to confirm the pulse has ended and the sum has stayed in place.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        CARRY_D  = 1'b0,
        CARRY_JK = 1'b1
    } carry_mode_e;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] data_q,
    output logic         ser_out
);

    logic [W-1:0] data_d;

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = par_in;
        end else if (shift) begin
            data_d = {ser_in, data_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign ser_out = data_q[0];

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(data_q));

    p_shift_toward_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (data_q[W-2:0] == $past(data_q[W-1:1])));

    p_serial_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (data_q[W-1] == $past(ser_in)));

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (data_q == $past(par_in)));

endmodule

// File: rtl/bsa_carry.sv
module bsa_carry
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic jk_mode,
    input  logic x,
    input  logic y,
    output logic c_q,
    output logic sum_bit
);

    carry_mode_e mode;
    logic        c_d;
    logic        d_next;
    logic        jk_set;
    logic        jk_rst;
    logic        jk_next;

    always_comb begin
        mode    = carry_mode_e'(jk_mode);
        sum_bit = x ^ y ^ c_q;
        d_next  = majority3(x, y, c_q);
        jk_set  = x & y;
        jk_rst  = ~x & ~y;
        jk_next = (jk_set & ~c_q) | (~jk_rst & c_q);
        c_d     = c_q;
        if (clr) begin
            c_d = 1'b0;
        end else if (step) begin
            c_d = (mode == CARRY_JK) ? jk_next : d_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    p_clear_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !c_q);

    p_jk_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && jk_mode && x && y) |=> c_q);

    p_jk_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && jk_mode && !x && !y) |=> !c_q);

    p_jk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && jk_mode && (x != y)) |=> $stable(c_q));

    p_d_follows_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !jk_mode && (x == y)) |=> (c_q == $past(x)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(c_q));

endmodule

// File: rtl/bsa_counter.sv
module bsa_counter #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step_req,
    output logic step,
    output logic done
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(W);
    localparam logic [CW-1:0] LAST_VAL = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cnt_state_t;

    cnt_state_t st_d;
    cnt_state_t st_q;

    always_comb begin
        step      = step_req && !load && (st_q.cnt != '0);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (load) begin
            st_d.cnt = LOAD_VAL;
        end else if (step) begin
            st_d.cnt = st_q.cnt - LAST_VAL;
            if (st_q.cnt == LAST_VAL) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st_q.cnt == $past(st_q.cnt) - LAST_VAL));

    p_stopped_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !load) |=> (st_q.cnt == '0));

    p_no_step_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !step);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (st_q.cnt == '0));

endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
    import bsa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] augend_in,
    input  logic [W-1:0] addend_in,
    input  logic         shift_en,
    input  logic         jk_mode,
    input  logic         addend_recirc,
    input  logic         addend_ser_in,
    output logic [W:0]   result,
    output logic [W-1:0] addend_out,
    output logic         done
);

    logic         step;
    logic         x_bit;
    logic         y_bit;
    logic         sum_bit;
    logic         carry_q;
    logic         addend_feed;
    logic [W-1:0] augend_q;

    assign addend_feed = addend_recirc ? y_bit : addend_ser_in;

    bsa_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_req (shift_en),
        .step     (step),
        .done     (done)
    );

    bsa_shreg #(.W(W)) u_augend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .par_in  (augend_in),
        .shift   (step),
        .ser_in  (sum_bit),
        .data_q  (augend_q),
        .ser_out (x_bit)
    );

    bsa_shreg #(.W(W)) u_addend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .par_in  (addend_in),
        .shift   (step),
        .ser_in  (addend_feed),
        .data_q  (addend_out),
        .ser_out (y_bit)
    );

    bsa_carry u_carry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .step    (step),
        .jk_mode (jk_mode),
        .x       (x_bit),
        .y       (y_bit),
        .c_q     (carry_q),
        .sum_bit (sum_bit)
    );

    assign result = {carry_q, augend_q};

    p_recirc_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && addend_recirc) |=> (addend_out[W-1] == $past(addend_out[0])));

    p_sum_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (augend_q[W-1] == ($past(augend_q[0]) ^ $past(addend_out[0]) ^ $past(carry_q))));

endmodule

// File: tb/serial_add_unit_test.sv
module serial_add_unit_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] augend_in = '0;
    logic [W-1:0] addend_in = '0;
    logic         shift_en = 1'b0;
    logic         jk_mode = 1'b0;
    logic         addend_recirc = 1'b1;
    logic         addend_ser_in = 1'b0;
    logic [W:0]   result;
    logic [W-1:0] addend_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    serial_add_unit #(.W(W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .augend_in     (augend_in),
        .addend_in     (addend_in),
        .shift_en      (shift_en),
        .jk_mode       (jk_mode),
        .addend_recirc (addend_recirc),
        .addend_ser_in (addend_ser_in),
        .result        (result),
        .addend_out    (addend_out),
        .done          (done)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        augend_in = a;
        addend_in = b;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 result", 32'(result), 0);
        check("R1 addend", 32'(addend_out), 0);
        check("R1 done", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Full addition; optional pause after the third shift.
    task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic mode, input logic pause);
        logic [W:0] exp_sum;
        logic [W:0] snap;
        exp_sum = {1'b0, a} + {1'b0, b};
        jk_mode = mode;
        addend_recirc = 1'b1;
        do_load(a, b);
        check("R2 loaded result", 32'(result), 32'({1'b0, a}));
        check("R2 loaded addend", 32'(addend_out), 32'(b));
        shift_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0) begin
                check("R4 first sum bit", 32'(result[W-1]), 32'(a[0] ^ b[0]));
                check("R4 augend shifted", 32'(result[W-2:0]), 32'(a[W-1:1]));
                check(mode ? "R6 first carry" : "R5 first carry",
                      32'(result[W]), 32'(a[0] & b[0]));
            end
            if (i < W - 1) check("R8 no early done", 32'(done), 0);
            if (pause && i == 2) begin
                shift_en = 1'b0;
                snap = result;
                repeat (3) begin
                    @(negedge clk);
                    check("R3 paused result", 32'(result), 32'(snap));
                    check("R3 paused done", 32'(done), 0);
                end
                shift_en = 1'b1;
            end
        end
        check("R8 done pulse", 32'(done), 1);
        check(mode ? "R9 sum jk" : "R9 sum d", 32'(result), 32'(exp_sum));
        check("R7 addend kept", 32'(addend_out), 32'(b));
        @(negedge clk);
        check("R8 done ends", 32'(done), 0);
        check("R8 no extra shift", 32'(result), 32'(exp_sum));
        shift_en = 1'b0;
    endtask

    // External serial input for the addend register.
    task automatic t_serial_in(input logic [W-1:0] a, input logic [W-1:0] b);
        jk_mode = 1'b1;
        addend_recirc = 1'b0;
        addend_ser_in = 1'b1;
        do_load(a, b);
        shift_en = 1'b1;
        repeat (W) @(posedge clk);
        @(negedge clk);
        check("R7 serial fill", 32'(addend_out), 32'({W{1'b1}}));
        check("R9 sum with serial fill", 32'(result), 32'({1'b0, a} + {1'b0, b}));
        shift_en = 1'b0;
        addend_recirc = 1'b1;
        addend_ser_in = 1'b0;
    endtask

    // Reload mid-run with shift_en high; stale carry must be cleared.
    task automatic t_reload(input logic mode);
        jk_mode = mode;
        do_load(8'hFF, 8'h01);
        shift_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R6 carry mid-run", 32'(result[W]), 1);
        augend_in = 8'h12;
        addend_in = 8'h34;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R2 load priority", 32'(result), 32'({1'b0, 8'h12}));
        check("R2 addend reload", 32'(addend_out), 32'h34);
        repeat (W) @(posedge clk);
        @(negedge clk);
        check("R9 sum after reload", 32'(result), 32'h46);
        check("R8 done after reload", 32'(done), 1);
        shift_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_add(8'h00, 8'h00, 1'b0, 1'b0);
        t_add(8'hFF, 8'h01, 1'b0, 1'b0);
        t_add(8'hFF, 8'hFF, 1'b1, 1'b0);
        t_add(8'hA5, 8'h5A, 1'b1, 1'b0);
        t_add(8'h3C, 8'hC7, 1'b0, 1'b1);
        t_add(8'h9B, 8'h6D, 1'b1, 1'b1);
        t_add(8'h80, 8'h80, 1'b1, 1'b0);
        t_add(8'h57, 8'h2B, 1'b0, 1'b0);
        t_serial_in(8'h41, 8'hC3);
        t_reload(1'b1);
        t_reload(1'b0);
        summary();
        $finish;
    end

endmodule